// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin-Mode Decoding

This block is a clocked, synthesizable stand-in for a byte-wide one-time-programmable memory and the control pins around it. A host drives an address, an active-low chip select and an active-low output enable. Two boolean flags stand in for the high-voltage levels. `oe_hv` means that the output-enable pin is at program-supply level. `a9_hv` means that address line 9 is at identification level. From these inputs the block selects one of seven modes: array read, program verify, output off, standby, program, program inhibit or identification. It then either drives the stored byte, drives a fixed identification code, floats the bus, or takes a byte in for programming.

Every location powers up erased at 0xFF. Programming can only clear bits, so the stored byte becomes the old value ANDed with the new one. A program pulse is a stretch of cycles with chip select low while the supply flag is set. The write is committed when chip select rises, provided the supply flag is still set at that point. The data bus is split into `din`, `dout` and a driver enable `dout_en`, and the chip-level pad ties these together. `ADDR_W` sets the depth. The default of 12 keeps elaboration light, and the full-size part uses 16.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset, every location reads as 0xFF.
- R2: When `ce_n`=0, `oe_n`=0, `oe_hv`=0 and `a9_hv`=0, `dout_en` is 1 and `dout` shows the byte stored at `addr` in the same cycle. This covers both normal read and program verify.
- R3: When `ce_n`=0, `oe_n`=1 and `oe_hv`=0, `dout_en` is 0.
- R4: When `ce_n`=1, `dout_en` is 0 whatever the other inputs are. When `oe_hv`=1 at the same time (program inhibit), no location changes.
- R5: While `ce_n`=0 and `oe_hv`=1, `dout_en` is 0. The block captures `addr` and `din` on every such cycle. On the first clock edge that sees `ce_n`=1 with `oe_hv` still 1, it writes the last captured byte to the last captured address.
- R6: A write clears bits only: the new stored value is the old value AND `din`.
- R7: If `oe_hv` falls before `ce_n` rises, the pulse is abandoned and no location changes.
- R8: When `ce_n`=0, `oe_n`=0, `oe_hv`=0 and `a9_hv`=1, the block is in identification mode and ignores the value of address bit 9. If every other address bit except bit 0 is low, `dout` is 0x1E for `addr[0]`=0 and 0x0D for `addr[0]`=1.
- R9: In identification mode, if any address bit other than bits 0 and 9 is high, `dout` is 0xFF and `id_addr_err` is 1. Outside identification mode, `id_addr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; erases the array |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low; its rising edge ends a program pulse |
| oe_n | input | 1 | Output enable, active low, at normal level |
| oe_hv | input | 1 | Output-enable pin at program-supply level |
| a9_hv | input | 1 | Address line 9 at identification level |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read or identification byte |
| dout_en | output | 1 | Data bus driver enable |
| id_addr_err | output | 1 | Identification requested with a stray address bit high |

## Verification
`dout`, `dout_en` and `id_addr_err` are combinational functions of the pins and the stored array, so their values are due in the same cycle as the stimulus. The bench changes inputs just after a falling edge and samples one nanosecond later, before the next rising edge. A programmed byte lands on the rising edge that sees chip select high with the supply flag still set. The bench therefore reads it back only after the next falling edge. The abandoned-pulse and inhibit cases are checked the same way, by reading the target address after the cycle in which a write could have happened.

// File: rtl/otp_byte_mem.sv
module otp_byte_mem #(
  parameter int ADDR_W = 12,
  parameter logic [7:0] MFR_CODE = 8'h1E,
  parameter logic [7:0] DEV_CODE = 8'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              id_addr_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ID_FREE = ADDR_W'(1) | (ADDR_W'(1) << 9);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] pgm_addr;
  logic [7:0]        pgm_data;
  logic              armed;

  wire in_pulse = !ce_n && oe_hv;
  wire commit   = armed && ce_n && oe_hv;
  wire rd_mode  = !ce_n && !oe_n && !oe_hv;
  wire id_mode  = rd_mode && a9_hv;
  wire id_bad   = |(addr & ~ID_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= 8'hFF;
    end else begin
      armed <= in_pulse;
      if (in_pulse) begin
        pgm_addr <= addr;
        pgm_data <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
    end
  end

  always_comb begin
    if (!id_mode)    dout = mem[addr];
    else if (id_bad) dout = 8'hFF;
    else             dout = addr[0] ? DEV_CODE : MFR_CODE;
  end

  assign dout_en     = rd_mode;
  assign id_addr_err = id_mode && id_bad;

  // R3
  off_when_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n && !oe_hv) |-> !dout_en);

  // R4
  standby_floats_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> !dout_en);

  // R5
  pulse_floats_chk: assert property (@(posedge clk) disable iff (rst)
    in_pulse |-> !dout_en);

  // R6
  and_write_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> mem[$past(pgm_addr)] == ($past(mem[pgm_addr]) & $past(pgm_data)));

  // R7
  no_write_without_hv_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_hv |=> mem[$past(addr)] == $past(mem[addr]));

  // R9
  bad_id_reads_ff_chk: assert property (@(posedge clk) disable iff (rst)
    id_addr_err |-> (dout == 8'hFF && dout_en));
endmodule

// File: tb/otp_byte_mem_tb.sv
module otp_byte_mem_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
  logic [7:0]    din = 8'hFF;
  logic [7:0]    dout;
  logic          dout_en, id_addr_err;
  int            checks = 0, errors = 0;

  always #10 clk = ~clk;

  otp_byte_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .oe_hv(oe_hv), .a9_hv(a9_hv), .din(din), .dout(dout),
    .dout_en(dout_en), .id_addr_err(id_addr_err)
  );

  // {ce_n, oe_n, oe_hv, a9_hv, addr[11:0], exp_en, exp_dout, exp_err, req}
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0000, 12'h005, 1'b1, 8'h5A, 1'b0, 4'd2},  // R2
    {4'b0000, 12'hFFF, 1'b1, 8'h3C, 1'b0, 4'd2},  // R2
    {4'b0000, 12'h000, 1'b1, 8'h00, 1'b0, 4'd2},  // R2
    {4'b0000, 12'h123, 1'b1, 8'hFF, 1'b0, 4'd1},  // R1
    {4'b0100, 12'h005, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
    {4'b1000, 12'h005, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    {4'b1010, 12'h005, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
    {4'b0001, 12'h200, 1'b1, 8'h1E, 1'b0, 4'd8},  // R8
    {4'b0001, 12'h001, 1'b1, 8'h0D, 1'b0, 4'd8},  // R8
    {4'b0001, 12'h000, 1'b1, 8'h1E, 1'b0, 4'd8},  // R8
    {4'b0001, 12'h011, 1'b1, 8'hFF, 1'b1, 4'd9},  // R9
    {4'b0101, 12'h011, 1'b0, 8'h00, 1'b0, 4'd9},  // R9
    {4'b0000, 12'h011, 1'b1, 8'hFF, 1'b0, 4'd9}   // R9
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; oe_hv = 1'b0; a9_hv = 1'b0; addr = a;
    #1 chk(req, {dout_en, dout}, {1'b1, exp});
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    oe_n = 1'b1; oe_hv = 1'b1; ce_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    oe_hv = 1'b0; din = 8'hFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(12'h000, 8'hFF, "R1");
    rd(12'hFFF, 8'hFF, "R1");

    // R5: bus floats during a pulse
    @(negedge clk);
    oe_n = 1'b0; oe_hv = 1'b1; ce_n = 1'b0; addr = 12'h005; din = 8'h5A;
    #1 chk("R5", {dout_en, 8'h00}, 9'h000);
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    oe_hv = 1'b0; din = 8'hFF;
    pgm(12'hFFF, 8'h3C);
    pgm(12'h000, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      {ce_n, oe_n, oe_hv, a9_hv} = v[29:26];
      addr = v[25:14];
      #1;
      tag = $sformatf("R%0d", v[3:0]);
      chk(tag, {dout_en, v[13] ? dout : 8'h00}, {v[13], v[13] ? v[12:5] : 8'h00});
      chk(tag, {8'h00, id_addr_err}, {8'h00, v[4]});
    end
    @(negedge clk);
    ce_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; oe_n = 1'b1;

    // R6: second write ANDs into the earlier value
    pgm(12'h005, 8'hF0);
    rd(12'h005, 8'h50, "R6");

    // R7: supply drops before chip select rises
    @(negedge clk);
    oe_n = 1'b1; oe_hv = 1'b1; ce_n = 1'b0; addr = 12'h123; din = 8'h00;
    @(negedge clk);
    oe_hv = 1'b0;
    @(negedge clk);
    ce_n = 1'b1;
    rd(12'h123, 8'hFF, "R7");

    // R4: inhibit, chip select held high under program supply
    @(negedge clk);
    ce_n = 1'b1; oe_hv = 1'b1; addr = 12'h124; din = 8'h00;
    repeat (3) @(negedge clk);
    oe_hv = 1'b0;
    rd(12'h124, 8'hFF, "R4");

    // R5: write lands on the rising edge of chip select, at last captured address
    @(negedge clk);
    oe_n = 1'b1; oe_hv = 1'b1; ce_n = 1'b0; addr = 12'h300; din = 8'hAA;
    @(negedge clk);
    addr = 12'h301; din = 8'h0F;
    @(negedge clk);
    ce_n = 1'b1; addr = 12'h400; din = 8'h00;
    @(negedge clk);
    oe_hv = 1'b0;
    rd(12'h301, 8'h0F, "R5");
    rd(12'h300, 8'hFF, "R5");
    rd(12'h400, 8'hFF, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule